// File: doc/BRIEF.md
# Periodic Capacitance/ESR Measurement Scheduler

This block decides when a combined capacitance and series-resistance measurement of a capacitor stack runs. Software programs a repeat period in units of ten seconds. The block counts that period down from a prescaler pulse input and then waits for the analog front end to report acceptable operating conditions. It then runs the capacitance step and the ESR step in turn on an external measurement engine. A software start command requests a run as soon as conditions allow. A software stop command aborts a run that is in progress. A period of zero turns off automatic repetition.

The controller has five states. Idle is reached from reset. Scheduled is entered by a nonzero period write, or when a run finishes with a nonzero period; it counts down and goes to Pending when the count expires. Pending waits for `cond_ok`, then enters CapStep (the measurement begins). CapStep goes to EsrStep when capacitance completes. A run finishes on a capacitance failure, on an ESR completion or failure, or on a stop, in either step. When a run finishes, the controller goes to Pending if a start request is still set. Otherwise it goes to Scheduled with the counter reloaded when the period is nonzero, and to Idle when the period is zero. A start request moves Idle or Scheduled to Pending. In Idle or Scheduled, a zero-period write forces Idle.

Top module: `meas_sched`

## Requirements
- R1: After reset every status output, every engine strobe, `start_req` and `chg_hold` are 0, and the controller is in Idle.
- R2: In Idle or Scheduled, with no start request set, a write of nonzero P makes `st_scheduled` 1 on the next cycle. `st_pending` rises on the cycle after the P×TICK_DIV-th `prescale_pulse` that follows the load cycle. A pulse in the load cycle itself is not counted. A write of zero returns the controller to Idle.
- R3: A start write sets `start_req` on the next cycle and moves Idle or Scheduled to Pending one cycle later. `start_req` stays 1 until the cycle in which `eng_cap_start` is 1, and it falls in that cycle.
- R4: In Pending with `cond_ok` high, the next cycle shows `st_active`=1, a one-cycle `eng_cap_start` and `chg_hold`=1. `chg_hold` is 1 only during the capacitance step.
- R5: A `cap_done_in` during the capacitance step sets `st_cap_done`, gives a one-cycle `eng_esr_start` and ends `chg_hold`.
- R6: An `esr_done_in` during the ESR step sets `st_esr_done` and finishes the run. A finished run goes to Pending if `start_req` is 1. Otherwise it goes to Scheduled, with the counter reloaded, when the period is nonzero, and to Idle when the period is zero.
- R7: A `cap_fail_in` during the capacitance step sets both `st_cap_failed` and `st_esr_failed`, skips the ESR step and finishes the run. An `esr_fail_in` during the ESR step sets `st_esr_failed`. A fail input takes priority over a done input in the same cycle.
- R8: A stop write during either step gives a one-cycle `eng_abort` and finishes the run, with priority over engine inputs. A stop write in any other state has no effect.
- R9: The four result flags are cleared in the cycle a run begins.
- R10: At most one of `st_scheduled`, `st_pending` and `st_active` is 1 at any time.
- R11: Engine done and fail inputs have no effect outside the step they belong to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prescale_pulse | input | 1 | Time-base pulse; TICK_DIV pulses make one period unit |
| cond_ok | input | 1 | Operating conditions allow a measurement |
| wr_period | input | 1 | Write strobe for the repeat period |
| period_in | input | PERIOD_W | Repeat period value, in period units |
| wr_ctl | input | 1 | Write strobe for the command bits |
| ctl_start | input | 1 | Start command, sampled with wr_ctl |
| ctl_stop | input | 1 | Stop command, sampled with wr_ctl |
| cap_done_in | input | 1 | Engine: capacitance step completed |
| cap_fail_in | input | 1 | Engine: capacitance step failed |
| esr_done_in | input | 1 | Engine: ESR step completed |
| esr_fail_in | input | 1 | Engine: ESR step failed |
| eng_cap_start | output | 1 | One-cycle strobe starting the capacitance step |
| eng_esr_start | output | 1 | One-cycle strobe starting the ESR step |
| eng_abort | output | 1 | One-cycle strobe aborting the engine |
| chg_hold | output | 1 | Charger held off for the capacitance step |
| start_req | output | 1 | Start command bit readback |
| st_scheduled | output | 1 | Counting down to the next run |
| st_pending | output | 1 | Due, waiting for acceptable conditions |
| st_active | output | 1 | Measurement in progress |
| st_cap_done | output | 1 | Capacitance step completed in the latest run |
| st_esr_done | output | 1 | ESR step completed in the latest run |
| st_cap_failed | output | 1 | Latest capacitance attempt failed |
| st_esr_failed | output | 1 | Latest ESR attempt failed or was skipped |

## Verification
The controller state is visible one cycle after any event: the three status bits give a one-hot view of the state, and the strobes mark each transition into a step. A wrong state or a miscounted period therefore shows up within one cycle, as a status bit that differs from a cycle-accurate reference. A miscounted period shows as `st_pending` rising one or more pulses early or late. A lost or stuck start request shows as `start_req` failing to fall in the cycle of `eng_cap_start`. Flags set in the wrong step, or not cleared, show up in the cycle a step ends or a new run begins.

// File: rtl/meas_sched_pkg.sv
package meas_sched_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_SCHED = 3'd1,
        S_PEND  = 3'd2,
        S_CAP   = 3'd3,
        S_ESR   = 3'd4
    } sched_state_e;

    localparam int unsigned FLAG_CAP_DONE = 0;
    localparam int unsigned FLAG_ESR_DONE = 1;
    localparam int unsigned FLAG_CAP_FAIL = 2;
    localparam int unsigned FLAG_ESR_FAIL = 3;
    localparam int unsigned NUM_FLAGS     = 4;

endpackage

// File: rtl/sched_tick_div.sv
module sched_tick_div #(
    parameter int unsigned TICK_DIV = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic pulse,
    output logic unit_tick
);
    localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign unit_tick = pulse && !clr && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (pulse) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sched_countdown.sv
module sched_countdown #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    assign expired = tick && !load && (cnt_q == W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/sched_results.sv
module sched_results
    import meas_sched_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_all,
    input  logic [NUM_FLAGS-1:0] set_vec,
    output logic [NUM_FLAGS-1:0] flags
);
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (clr_all) begin
                flags[i] <= 1'b0;
            end else if (set_vec[i]) begin
                flags[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sched_fsm.sv
module sched_fsm
    import meas_sched_pkg::*;
#(
    parameter int unsigned PERIOD_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_period,
    input  logic [PERIOD_W-1:0]  period_in,
    input  logic                 wr_ctl,
    input  logic                 ctl_start,
    input  logic                 ctl_stop,
    input  logic                 cond_ok,
    input  logic                 cap_done_in,
    input  logic                 cap_fail_in,
    input  logic                 esr_done_in,
    input  logic                 esr_fail_in,
    input  logic                 expired,
    output logic                 load,
    output logic [PERIOD_W-1:0]  load_val,
    output logic                 begin_run,
    output logic [NUM_FLAGS-1:0] set_vec,
    output logic                 eng_cap_start,
    output logic                 eng_esr_start,
    output logic                 eng_abort,
    output logic                 chg_hold,
    output logic                 start_req,
    output logic                 st_scheduled,
    output logic                 st_pending,
    output logic                 st_active
);
    sched_state_e        state_q, state_d;
    logic [PERIOD_W-1:0] period_q;
    logic                start_q;
    logic                stop_cmd;
    logic                finish;
    logic                go_esr;
    logic                abort_now;
    logic [PERIOD_W-1:0] eff_period;

    assign stop_cmd   = wr_ctl && ctl_stop;
    assign eff_period = wr_period ? period_in : period_q;
    assign load_val   = eff_period;

    // Next-state decision
    always_comb begin
        state_d   = state_q;
        load      = 1'b0;
        begin_run = 1'b0;
        finish    = 1'b0;
        go_esr    = 1'b0;
        abort_now = 1'b0;
        set_vec   = '0;
        unique case (state_q)
            S_IDLE: begin
                if (start_q) begin
                    state_d = S_PEND;
                end else if (wr_period && (period_in != '0)) begin
                    state_d = S_SCHED;
                    load    = 1'b1;
                end
            end
            S_SCHED: begin
                if (start_q) begin
                    state_d = S_PEND;
                end else if (wr_period) begin
                    if (period_in != '0) begin
                        load = 1'b1;
                    end else begin
                        state_d = S_IDLE;
                    end
                end else if (expired) begin
                    state_d = S_PEND;
                end
            end
            S_PEND: begin
                if (cond_ok) begin
                    state_d   = S_CAP;
                    begin_run = 1'b1;
                end
            end
            S_CAP: begin
                if (stop_cmd) begin
                    abort_now = 1'b1;
                    finish    = 1'b1;
                end else if (cap_fail_in) begin
                    set_vec[FLAG_CAP_FAIL] = 1'b1;
                    set_vec[FLAG_ESR_FAIL] = 1'b1;
                    finish                 = 1'b1;
                end else if (cap_done_in) begin
                    set_vec[FLAG_CAP_DONE] = 1'b1;
                    state_d                = S_ESR;
                    go_esr                 = 1'b1;
                end
            end
            S_ESR: begin
                if (stop_cmd) begin
                    abort_now = 1'b1;
                    finish    = 1'b1;
                end else if (esr_fail_in) begin
                    set_vec[FLAG_ESR_FAIL] = 1'b1;
                    finish                 = 1'b1;
                end else if (esr_done_in) begin
                    set_vec[FLAG_ESR_DONE] = 1'b1;
                    finish                 = 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
        if (finish) begin
            if (start_q) begin
                state_d = S_PEND;
            end else if (eff_period != '0) begin
                state_d = S_SCHED;
                load    = 1'b1;
            end else begin
                state_d = S_IDLE;
            end
        end
    end

    // State, period and start-command registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            period_q <= '0;
            start_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (wr_period) begin
                period_q <= period_in;
            end
            start_q <= (start_q && !begin_run) || (wr_ctl && ctl_start);
        end
    end

    // Engine strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_cap_start <= 1'b0;
            eng_esr_start <= 1'b0;
            eng_abort     <= 1'b0;
        end else begin
            eng_cap_start <= begin_run;
            eng_esr_start <= go_esr;
            eng_abort     <= abort_now;
        end
    end

    assign start_req    = start_q;
    assign st_scheduled = (state_q == S_SCHED);
    assign st_pending   = (state_q == S_PEND);
    assign st_active    = (state_q == S_CAP) || (state_q == S_ESR);
    assign chg_hold     = (state_q == S_CAP);
endmodule

// File: rtl/meas_sched.sv
module meas_sched
    import meas_sched_pkg::*;
#(
    parameter int unsigned PERIOD_W = 16,
    parameter int unsigned TICK_DIV = 10000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prescale_pulse,
    input  logic                cond_ok,
    input  logic                wr_period,
    input  logic [PERIOD_W-1:0] period_in,
    input  logic                wr_ctl,
    input  logic                ctl_start,
    input  logic                ctl_stop,
    input  logic                cap_done_in,
    input  logic                cap_fail_in,
    input  logic                esr_done_in,
    input  logic                esr_fail_in,
    output logic                eng_cap_start,
    output logic                eng_esr_start,
    output logic                eng_abort,
    output logic                chg_hold,
    output logic                start_req,
    output logic                st_scheduled,
    output logic                st_pending,
    output logic                st_active,
    output logic                st_cap_done,
    output logic                st_esr_done,
    output logic                st_cap_failed,
    output logic                st_esr_failed
);
    logic                 load;
    logic [PERIOD_W-1:0]  load_val;
    logic                 unit_tick;
    logic                 expired;
    logic                 begin_run;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] flags;

    sched_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (load),
        .pulse     (prescale_pulse),
        .unit_tick (unit_tick)
    );

    sched_countdown #(.W(PERIOD_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .tick     (unit_tick),
        .expired  (expired)
    );

    sched_fsm #(.PERIOD_W(PERIOD_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_period     (wr_period),
        .period_in     (period_in),
        .wr_ctl        (wr_ctl),
        .ctl_start     (ctl_start),
        .ctl_stop      (ctl_stop),
        .cond_ok       (cond_ok),
        .cap_done_in   (cap_done_in),
        .cap_fail_in   (cap_fail_in),
        .esr_done_in   (esr_done_in),
        .esr_fail_in   (esr_fail_in),
        .expired       (expired),
        .load          (load),
        .load_val      (load_val),
        .begin_run     (begin_run),
        .set_vec       (set_vec),
        .eng_cap_start (eng_cap_start),
        .eng_esr_start (eng_esr_start),
        .eng_abort     (eng_abort),
        .chg_hold      (chg_hold),
        .start_req     (start_req),
        .st_scheduled  (st_scheduled),
        .st_pending    (st_pending),
        .st_active     (st_active)
    );

    sched_results u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (begin_run),
        .set_vec (set_vec),
        .flags   (flags)
    );

    assign st_cap_done   = flags[FLAG_CAP_DONE];
    assign st_esr_done   = flags[FLAG_ESR_DONE];
    assign st_cap_failed = flags[FLAG_CAP_FAIL];
    assign st_esr_failed = flags[FLAG_ESR_FAIL];
endmodule

// File: rtl/meas_sched_chk.sv
module meas_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_ctl,
    input logic ctl_stop,
    input logic eng_cap_start,
    input logic eng_abort,
    input logic chg_hold,
    input logic start_req,
    input logic st_scheduled,
    input logic st_pending,
    input logic st_active,
    input logic st_cap_done,
    input logic st_esr_done,
    input logic st_cap_failed,
    input logic st_esr_failed
);
    a_r10_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_scheduled, st_pending, st_active}));

    a_r4_hold_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        chg_hold |-> st_active);

    a_r4_active_entry_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_active) |-> eng_cap_start);

    a_r3_req_falls_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_req) |-> eng_cap_start);

    a_r9_flags_clear_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cap_start |-> (!st_cap_done && !st_esr_done && !st_cap_failed && !st_esr_failed));

    a_r7_capfail_marks_esr: assert property (@(posedge clk) disable iff (!rst_n)
        st_cap_failed |-> st_esr_failed);

    a_r8_abort_leaves_active: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |-> !st_active);

    a_r8_stop_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && ctl_stop && !st_active) |=> !eng_abort);
endmodule

bind meas_sched meas_sched_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_ctl        (wr_ctl),
    .ctl_stop      (ctl_stop),
    .eng_cap_start (eng_cap_start),
    .eng_abort     (eng_abort),
    .chg_hold      (chg_hold),
    .start_req     (start_req),
    .st_scheduled  (st_scheduled),
    .st_pending    (st_pending),
    .st_active     (st_active),
    .st_cap_done   (st_cap_done),
    .st_esr_done   (st_esr_done),
    .st_cap_failed (st_cap_failed),
    .st_esr_failed (st_esr_failed)
);

// File: tb/meas_sched_bench.sv
`timescale 1ns/1ps
module meas_sched_bench;
    localparam int PW  = 16;
    localparam int DIV = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prescale_pulse = 0, cond_ok = 0, wr_period = 0, wr_ctl = 0;
    logic ctl_start = 0, ctl_stop = 0;
    logic cap_done_in = 0, cap_fail_in = 0, esr_done_in = 0, esr_fail_in = 0;
    logic [PW-1:0] period_in = '0;
    logic eng_cap_start, eng_esr_start, eng_abort, chg_hold, start_req;
    logic st_scheduled, st_pending, st_active;
    logic st_cap_done, st_esr_done, st_cap_failed, st_esr_failed;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    meas_sched #(.PERIOD_W(PW), .TICK_DIV(DIV)) u_meas_sched (.*);

    // Reference model: 0 idle, 1 scheduled, 2 pending, 3 cap step, 4 esr step
    int m_state, m_rem;
    logic [PW-1:0] m_per;
    logic m_req, m_cd, m_ed, m_cf, m_ef, m_cs, m_es, m_ab;

    function automatic int load_count(input logic [PW-1:0] p);
        return int'(p) * DIV;
    endfunction

    always @(posedge clk) begin
        logic [PW-1:0] eff;
        logic fin, beg, stp;
        if (!rst_n) begin
            m_state <= 0; m_rem <= 0; m_per <= '0; m_req <= 0;
            m_cd <= 0; m_ed <= 0; m_cf <= 0; m_ef <= 0;
            m_cs <= 0; m_es <= 0; m_ab <= 0;
        end else begin
            eff = wr_period ? period_in : m_per;
            fin = 0; beg = 0;
            stp = wr_ctl && ctl_stop;
            m_cs <= 0; m_es <= 0; m_ab <= 0;
            if (wr_period) m_per <= period_in;
            case (m_state)
                0: if (m_req) m_state <= 2;
                   else if (wr_period && period_in != 0) begin
                       m_state <= 1; m_rem <= load_count(period_in);
                   end
                1: if (m_req) m_state <= 2;
                   else if (wr_period) begin
                       if (period_in != 0) m_rem <= load_count(period_in);
                       else m_state <= 0;
                   end else if (prescale_pulse) begin
                       if (m_rem == 1) m_state <= 2;
                       m_rem <= m_rem - 1;
                   end
                2: if (cond_ok) begin
                       beg = 1; m_state <= 3; m_cs <= 1;
                       m_cd <= 0; m_ed <= 0; m_cf <= 0; m_ef <= 0;
                   end
                3: if (stp) begin m_ab <= 1; fin = 1; end
                   else if (cap_fail_in) begin m_cf <= 1; m_ef <= 1; fin = 1; end
                   else if (cap_done_in) begin m_cd <= 1; m_state <= 4; m_es <= 1; end
                4: if (stp) begin m_ab <= 1; fin = 1; end
                   else if (esr_fail_in) begin m_ef <= 1; fin = 1; end
                   else if (esr_done_in) begin m_ed <= 1; fin = 1; end
                default: m_state <= 0;
            endcase
            if (fin) begin
                if (m_req) m_state <= 2;
                else if (eff != 0) begin m_state <= 1; m_rem <= load_count(eff); end
                else m_state <= 0;
            end
            m_req <= (m_req && !beg) || (wr_ctl && ctl_start);
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(st_scheduled == (m_state == 1), "R2", "st_scheduled", st_scheduled, m_state == 1);
        chk(st_pending == (m_state == 2), "R3", "st_pending", st_pending, m_state == 2);
        chk(st_active == (m_state >= 3), "R4", "st_active", st_active, m_state >= 3);
        chk(chg_hold == (m_state == 3), "R4", "chg_hold", chg_hold, m_state == 3);
        chk(start_req == m_req, "R3", "start_req", start_req, m_req);
        chk(eng_cap_start == m_cs, "R4", "eng_cap_start", eng_cap_start, m_cs);
        chk(eng_esr_start == m_es, "R5", "eng_esr_start", eng_esr_start, m_es);
        chk(eng_abort == m_ab, "R8", "eng_abort", eng_abort, m_ab);
        chk(st_cap_done == m_cd, "R5", "st_cap_done", st_cap_done, m_cd);
        chk(st_esr_done == m_ed, "R6", "st_esr_done", st_esr_done, m_ed);
        chk(st_cap_failed == m_cf, "R7", "st_cap_failed", st_cap_failed, m_cf);
        chk(st_esr_failed == m_ef, "R7", "st_esr_failed", st_esr_failed, m_ef);
        chk($countones({st_scheduled, st_pending, st_active}) <= 1, "R10", "status count",
            $countones({st_scheduled, st_pending, st_active}), 1);
    endtask

    // Apply the inputs set by the caller for one clock, then clear the one-shot ones.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        prescale_pulse = 0; wr_period = 0; wr_ctl = 0; ctl_start = 0; ctl_stop = 0;
        cap_done_in = 0; cap_fail_in = 0; esr_done_in = 0; esr_fail_in = 0;
        compare_all();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(!st_scheduled && !st_pending && !st_active && !start_req && !chg_hold &&
            !eng_cap_start && !eng_esr_start && !eng_abort && !st_cap_done &&
            !st_esr_done && !st_cap_failed && !st_esr_failed, "R1", "reset outputs", 0, 0);

        // R11: engine inputs in Idle have no effect
        cap_done_in = 1; cap_fail_in = 1; esr_done_in = 1; esr_fail_in = 1; step();
        chk(!st_cap_done && !st_cap_failed && !st_esr_done && !st_esr_failed && !st_active,
            "R11", "flags after idle engine inputs", st_cap_failed, 0);

        // R2: period 2 -> 2*DIV pulses
        wr_period = 1; period_in = 16'd2; prescale_pulse = 1; step();
        chk(st_scheduled, "R2", "scheduled after write", st_scheduled, 1);
        for (int i = 0; i < 2 * DIV - 1; i++) begin prescale_pulse = 1; step(); end
        chk(st_scheduled && !st_pending, "R2", "still scheduled before last pulse", st_pending, 0);
        prescale_pulse = 1; step();
        chk(st_pending, "R2", "pending after last pulse", st_pending, 1);

        // R4: begin run
        cond_ok = 1; step();
        chk(st_active && eng_cap_start && chg_hold, "R4", "run begins", st_active, 1);
        cond_ok = 0;
        // R11: esr inputs during capacitance step ignored
        esr_done_in = 1; step();
        chk(!st_esr_done && chg_hold, "R11", "esr done ignored in cap step", st_esr_done, 0);
        // R5
        cap_done_in = 1; step();
        chk(st_cap_done && eng_esr_start && !chg_hold && st_active, "R5", "esr step", st_cap_done, 1);
        // R6
        esr_done_in = 1; step();
        chk(st_esr_done && st_scheduled, "R6", "finish to scheduled", st_scheduled, 1);

        // R3: start request from scheduled
        wr_ctl = 1; ctl_start = 1; step();
        chk(start_req, "R3", "start_req set", start_req, 1);
        step();
        chk(st_pending && start_req, "R3", "pending holds request", start_req, 1);
        cond_ok = 1; step();
        chk(!start_req && eng_cap_start, "R3", "request clears at begin", start_req, 0);
        chk(!st_cap_done && !st_esr_done, "R9", "flags cleared at begin", st_esr_done, 0);
        cond_ok = 0;

        // R7: capacitance failure skips ESR
        cap_fail_in = 1; cap_done_in = 1; step();
        chk(st_cap_failed && st_esr_failed && !st_esr_done && !eng_esr_start && st_scheduled,
            "R7", "cap failure", st_esr_failed, 1);

        // R6: zero period returns to idle
        wr_period = 1; period_in = 16'd0; step();
        chk(!st_scheduled && !st_pending && !st_active, "R6", "zero period idle", st_scheduled, 0);

        // R8: stop during run, then stop in idle
        wr_ctl = 1; ctl_start = 1; step();
        step();
        cond_ok = 1; step(); cond_ok = 0;
        cap_done_in = 1; step();
        wr_ctl = 1; ctl_stop = 1; esr_done_in = 1; step();
        chk(eng_abort && !st_active && !st_esr_done && !st_scheduled, "R8", "abort to idle", eng_abort, 1);
        wr_ctl = 1; ctl_stop = 1; step();
        chk(!eng_abort, "R8", "stop ignored in idle", eng_abort, 0);

        // Random phase
        for (int n = 0; n < 6000; n++) begin
            prescale_pulse = ($urandom % 2) == 0;
            cond_ok        = ($urandom % 5) < 3;
            wr_period      = ($urandom % 50) == 0;
            period_in      = PW'($urandom % 4);
            wr_ctl         = ($urandom % 30) == 0;
            ctl_start      = $urandom % 2;
            ctl_stop       = ($urandom % 3) == 0;
            cap_done_in    = ($urandom % 8) == 0;
            cap_fail_in    = ($urandom % 20) == 0;
            esr_done_in    = ($urandom % 8) == 0;
            esr_fail_in    = ($urandom % 20) == 0;
            step();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule